// File: doc/BRIEF.md
# Reconfigurable Cache/Scratchpad Instruction Fetch Memory

This block serves instruction fetches from four equal storage banks. Each bank is switched at run time, through its own mode bit, between acting as one way of a four-way set-associative cache and acting as part of a scratchpad that holds one contiguous code chunk. A window check compares each fetch address with a programmable start (inclusive) and end (exclusive) address. On a window hit, every tag bank is kept idle and exactly one data bank is enabled. On a window miss, only the banks in cache mode are looked up.

Reconfiguration is a single command that carries the new mode mask and window. The command also copies the chunk from backing memory into the scratchpad banks, one word at a time. A cache miss refills a 16-byte line through the same backing-memory port. When every bank is in scratchpad mode, an address outside the window is read straight from backing memory and is not cached.

The control sequencer has four states. IDLE accepts commands and fetches. LOAD copies the chunk. REFILL reads a four-word line. BYPASS performs one uncached read. Its transitions are: IDLE to LOAD on a command; IDLE to REFILL on a miss while a cache way exists; IDLE to BYPASS on a miss with no cache way; LOAD to IDLE once the next copy address leaves the window; REFILL to IDLE on the acknowledge of the fourth word; BYPASS to IDLE on the acknowledge.

Top module: `flexmem_ifetch`

## Requirements
- R1: After reset the mode mask is all zero, so every bank is a cache way and every line is invalid. `busy`, `resp_valid`, `mem_req`, `tag_en` and `data_en` are all low.
- R2: A command (`cfg_valid` while not busy) installs `cfg_spm_mask`, where bit i set to 1 makes bank i scratchpad. It also installs the window `cfg_lo`..`cfg_hi`. It then reads backing memory at `cfg_lo`, `cfg_lo`+4, and onward, for as long as the address is inside the window (R4). Each word is written into the scratchpad. `busy` is high while this runs.
- R3: `tag_en` is never asserted for a bank in scratchpad mode. `tag_en` and `data_en` are asserted only in the cycle in which a fetch is accepted.
- R4: An address a is inside the window when lo <= a < hi and its ordinal (a-lo)[9:8] is below the number of scratchpad banks. Ordinal n maps to the n-th scratchpad bank counted upward from bank 0. (a-lo)[7:2] selects the word inside that bank.
- R5: On a window hit, `tag_en` is 0 and `data_en` is one-hot on the mapped bank. `resp_valid` rises in the next cycle with `resp_src`=1 and the word that was loaded for that address. No backing-memory read takes place.
- R6: On a window miss while any bank is in cache mode, `tag_en` and `data_en` both equal the set of cache-mode banks. The set is fetch_addr[7:4] and the tag is fetch_addr[15:8]. A tag hit responds in the next cycle with `resp_src`=0.
- R7: A cache miss reads the 16-byte line in four reads in ascending order, starting at the line base. `mem_req` is held with `mem_addr` stable until `mem_ack`. The requested word is then returned with `resp_src`=2.
- R8: The refill victim is the first cache-mode bank at or after a rotating pointer, wrapping at 4. The pointer then moves to the bank after the victim. It is 0 after reset.
- R9: Every bank whose mode bit changes on a command loses all of its cached lines.
- R10: With all four banks in scratchpad mode, a fetch outside the window performs exactly one backing-memory read of that address. It responds with `resp_src`=3 and allocates nothing, so a repeat fetch does the same.
- R11: `busy` is high in LOAD, REFILL and BYPASS. A fetch is accepted only while `busy` is low and no command is presented. No response is produced for a fetch offered while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_valid | input | 1 | Reconfigure and load command |
| cfg_spm_mask | input | 4 | Per-bank mode bits, 1 = scratchpad |
| cfg_lo | input | 16 | Window start byte address (word aligned) |
| cfg_hi | input | 16 | Window end byte address, exclusive |
| fetch_valid | input | 1 | Fetch request |
| fetch_addr | input | 16 | Fetch byte address (word aligned) |
| busy | output | 1 | Sequencer not in IDLE |
| resp_valid | output | 1 | One-cycle fetch response strobe |
| resp_data | output | 32 | Fetched instruction word |
| resp_src | output | 2 | 0 cache hit, 1 scratchpad, 2 refill, 3 uncached |
| tag_en | output | 4 | Tag bank lookup enables |
| data_en | output | 4 | Data bank lookup enables |
| mem_req | output | 1 | Backing-memory read request |
| mem_addr | output | 16 | Backing-memory byte address |
| mem_ack | input | 1 | Read data valid for the presented request |
| mem_rdata | input | 32 | Backing-memory read data |

## Verification
A wrong mode mask or a bad window bound shows up in the cycle a fetch is offered. The bank enables differ from the expected set before the clock edge, and the response one cycle later carries the wrong source code. A corrupted tag, valid bit or replacement pointer stays hidden until the affected set is fetched again. It then appears as a hit where the bench expects a refill, or the reverse, and the backing-memory traffic for that fetch changes from zero reads to four, or from four to zero. A load that stops early or writes to the wrong bank shows up only when a scratchpad word is fetched, as wrong response data.

// File: rtl/fm_pkg.sv
package fm_pkg;

    typedef enum logic [1:0] {
        SRC_CACHE  = 2'd0,
        SRC_SPM    = 2'd1,
        SRC_FILL   = 2'd2,
        SRC_DIRECT = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_REFILL,
        ST_BYPASS
    } state_e;

endpackage

// File: rtl/fm_spm_window.sv
module fm_spm_window #(
    parameter int ADDR_W     = 16,
    parameter int NBANK      = 4,
    parameter int BANK_BYTES = 256,
    parameter int WORD_BYTES = 4,
    localparam int BYTE_BITS = $clog2(BANK_BYTES),
    localparam int BSEL_W    = $clog2(NBANK),
    localparam int WB_BITS   = $clog2(WORD_BYTES),
    localparam int WIDX_W    = BYTE_BITS - WB_BITS
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] lo,
    input  logic [ADDR_W-1:0] hi,
    input  logic [NBANK-1:0]  mask,
    output logic              hit,
    output logic [NBANK-1:0]  sel,
    output logic [WIDX_W-1:0] idx
);
    localparam logic [BSEL_W:0] ONE = 1;

    logic [ADDR_W-1:0] off;
    logic [BSEL_W-1:0] ord;
    logic              in_span;
    logic              unused_low;

    assign off        = addr - lo;
    assign ord        = off[BYTE_BITS +: BSEL_W];
    assign in_span    = (addr >= lo) && (addr < hi) &&
                        ((off >> (BYTE_BITS + BSEL_W)) == '0);
    assign idx        = off[BYTE_BITS-1:WB_BITS];
    assign unused_low = ^off[WB_BITS-1:0];

    // Ordinal n selects the n-th scratchpad bank counted from bank 0 upward.
    always_comb begin
        logic [BSEL_W:0] cnt;
        cnt = '0;
        sel = '0;
        for (int b = 0; b < NBANK; b++) begin
            if (mask[b]) begin
                if (cnt == {1'b0, ord}) sel[b] = in_span;
                cnt = cnt + ONE;
            end
        end
    end

    assign hit = |sel;

endmodule

// File: rtl/fm_tag_store.sv
module fm_tag_store #(
    parameter int NWAY  = 4,
    parameter int SETS  = 16,
    parameter int TAG_W = 8,
    localparam int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NWAY-1:0]  look_en,
    input  logic [SET_W-1:0] look_set,
    input  logic [TAG_W-1:0] look_tag,
    output logic [NWAY-1:0]  hit_vec,
    input  logic             wr_en,
    input  logic [NWAY-1:0]  wr_way,
    input  logic [SET_W-1:0] wr_set,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [NWAY-1:0]  clr_ways
);
    for (genvar w = 0; w < NWAY; w++) begin : g_way
        logic [TAG_W-1:0] tags [SETS];
        logic [SETS-1:0]  valid;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid <= '0;
            end else if (clr_ways[w]) begin
                valid <= '0;
            end else if (wr_en && wr_way[w]) begin
                valid[wr_set] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (wr_en && wr_way[w]) tags[wr_set] <= wr_tag;
        end

        assign hit_vec[w] = look_en[w] && valid[look_set] &&
                            (tags[look_set] == look_tag);
    end

endmodule

// File: rtl/fm_data_store.sv
module fm_data_store #(
    parameter int NBANK  = 4,
    parameter int WORDS  = 64,
    parameter int WORD_W = 32,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic [NBANK-1:0]  rd_sel,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [NBANK-1:0]  wr_sel,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data
);
    logic [WORD_W-1:0] bank_q [NBANK];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [WORD_W-1:0] mem [WORDS];

        always_ff @(posedge clk) begin
            if (wr_en && wr_sel[b]) mem[wr_idx] <= wr_data;
        end

        assign bank_q[b] = mem[rd_idx];
    end

    always_comb begin
        rd_data = '0;
        for (int b = 0; b < NBANK; b++) begin
            if (rd_sel[b]) rd_data = rd_data | bank_q[b];
        end
    end

endmodule

// File: rtl/flexmem_ifetch.sv
module flexmem_ifetch
    import fm_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int WORD_W     = 32,
    parameter int NBANK      = 4,
    parameter int BANK_BYTES = 256,
    parameter int LINE_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid,
    input  logic [NBANK-1:0]  cfg_spm_mask,
    input  logic [ADDR_W-1:0] cfg_lo,
    input  logic [ADDR_W-1:0] cfg_hi,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              busy,
    output logic              resp_valid,
    output logic [WORD_W-1:0] resp_data,
    output logic [1:0]        resp_src,
    output logic [NBANK-1:0]  tag_en,
    output logic [NBANK-1:0]  data_en,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata
);
    localparam int WORD_BYTES = WORD_W / 8;
    localparam int WB_BITS    = $clog2(WORD_BYTES);
    localparam int LINE_BITS  = $clog2(LINE_BYTES);
    localparam int BANK_BITS  = $clog2(BANK_BYTES);
    localparam int SETS       = BANK_BYTES / LINE_BYTES;
    localparam int SET_W      = $clog2(SETS);
    localparam int WPL_W      = LINE_BITS - WB_BITS;
    localparam int WPB        = BANK_BYTES / WORD_BYTES;
    localparam int WIDX_W     = BANK_BITS - WB_BITS;
    localparam int TAG_W      = ADDR_W - BANK_BITS;
    localparam int BSEL_W     = $clog2(NBANK);
    localparam logic [WPL_W-1:0] LAST_WORD = '1;

    state_e state_q, state_d;

    logic [NBANK-1:0]  spm_mask_q;
    logic [ADDR_W-1:0] lo_q, hi_q, ld_addr_q, req_addr_q;
    logic [NBANK-1:0]  victim_q;
    logic [WPL_W-1:0]  wcnt_q;
    logic [WORD_W-1:0] cap_q;
    logic [BSEL_W-1:0] rr_ptr_q;

    // window check
    logic [ADDR_W-1:0] win_addr;
    logic              win_hit;
    logic [NBANK-1:0]  win_sel;
    logic [WIDX_W-1:0] win_idx;

    assign win_addr = (state_q == ST_LOAD) ? ld_addr_q : fetch_addr;

    fm_spm_window #(
        .ADDR_W(ADDR_W), .NBANK(NBANK),
        .BANK_BYTES(BANK_BYTES), .WORD_BYTES(WORD_BYTES)
    ) u_win (
        .addr(win_addr), .lo(lo_q), .hi(hi_q), .mask(spm_mask_q),
        .hit(win_hit), .sel(win_sel), .idx(win_idx)
    );

    logic [NBANK-1:0] cache_ways;
    logic             any_cache, accept, cfg_go;
    assign cache_ways = ~spm_mask_q;
    assign any_cache  = |cache_ways;
    assign cfg_go     = (state_q == ST_IDLE) && cfg_valid;
    assign accept     = (state_q == ST_IDLE) && fetch_valid && !cfg_valid;

    // request fields
    logic [SET_W-1:0] req_set;
    logic [WPL_W-1:0] req_word;
    logic [TAG_W-1:0] req_tag;
    assign req_set  = req_addr_q[BANK_BITS-1:LINE_BITS];
    assign req_word = req_addr_q[LINE_BITS-1:WB_BITS];
    assign req_tag  = req_addr_q[ADDR_W-1:BANK_BITS];

    // tag store
    logic [NBANK-1:0] hit_vec, clr_ways;
    logic             cache_hit, tag_we;
    assign clr_ways  = cfg_go ? (cfg_spm_mask ^ spm_mask_q) : '0;
    assign tag_we    = (state_q == ST_REFILL) && mem_ack && (wcnt_q == LAST_WORD);
    assign cache_hit = |hit_vec;

    fm_tag_store #(.NWAY(NBANK), .SETS(SETS), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n),
        .look_en(tag_en),
        .look_set(fetch_addr[BANK_BITS-1:LINE_BITS]),
        .look_tag(fetch_addr[ADDR_W-1:BANK_BITS]),
        .hit_vec(hit_vec),
        .wr_en(tag_we), .wr_way(victim_q), .wr_set(req_set), .wr_tag(req_tag),
        .clr_ways(clr_ways)
    );

    // data store
    logic [NBANK-1:0]  rd_sel, wr_sel;
    logic [WIDX_W-1:0] rd_idx, wr_idx;
    logic [WORD_W-1:0] rd_data;
    logic              data_we;

    assign rd_sel  = win_hit ? win_sel : hit_vec;
    assign rd_idx  = win_hit ? win_idx : fetch_addr[BANK_BITS-1:WB_BITS];
    assign data_we = ((state_q == ST_LOAD) && win_hit && mem_ack) ||
                     ((state_q == ST_REFILL) && mem_ack);
    assign wr_sel  = (state_q == ST_LOAD) ? win_sel : victim_q;
    assign wr_idx  = (state_q == ST_LOAD) ? win_idx : {req_set, wcnt_q};

    fm_data_store #(.NBANK(NBANK), .WORDS(WPB), .WORD_W(WORD_W)) u_data (
        .clk(clk),
        .rd_sel(rd_sel), .rd_idx(rd_idx), .rd_data(rd_data),
        .wr_en(data_we), .wr_sel(wr_sel), .wr_idx(wr_idx), .wr_data(mem_rdata)
    );

    // round-robin victim among cache-mode banks
    logic [NBANK-1:0]  victim_oh;
    logic [BSEL_W-1:0] victim_idx;
    always_comb begin
        logic [BSEL_W-1:0] cand;
        logic              found;
        victim_oh  = '0;
        victim_idx = '0;
        found      = 1'b0;
        for (int k = 0; k < NBANK; k++) begin
            cand = rr_ptr_q + BSEL_W'(k);
            if (!found && cache_ways[cand]) begin
                found             = 1'b1;
                victim_idx        = cand;
                victim_oh[cand]   = 1'b1;
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cfg_valid)
                    state_d = ST_LOAD;
                else if (fetch_valid && !win_hit && !cache_hit)
                    state_d = any_cache ? ST_REFILL : ST_BYPASS;
            end
            ST_LOAD:   if (!win_hit) state_d = ST_IDLE;
            ST_REFILL: if (mem_ack && (wcnt_q == LAST_WORD)) state_d = ST_IDLE;
            ST_BYPASS: if (mem_ack) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy     = (state_q != ST_IDLE);
        mem_req  = 1'b0;
        mem_addr = '0;
        tag_en   = '0;
        data_en  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    tag_en  = win_hit ? '0 : cache_ways;
                    data_en = win_hit ? win_sel : cache_ways;
                end
            end
            ST_LOAD: begin
                mem_req  = win_hit;
                mem_addr = ld_addr_q;
            end
            ST_REFILL: begin
                mem_req  = 1'b1;
                mem_addr = {req_addr_q[ADDR_W-1:LINE_BITS], wcnt_q, {WB_BITS{1'b0}}};
            end
            ST_BYPASS: begin
                mem_req  = 1'b1;
                mem_addr = req_addr_q;
            end
            default: ;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            spm_mask_q <= '0;
            lo_q       <= '0;
            hi_q       <= '0;
            ld_addr_q  <= '0;
            req_addr_q <= '0;
            victim_q   <= '0;
            wcnt_q     <= '0;
            cap_q      <= '0;
            rr_ptr_q   <= '0;
            resp_valid <= 1'b0;
            resp_data  <= '0;
            resp_src   <= SRC_CACHE;
        end else begin
            resp_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (cfg_go) begin
                        spm_mask_q <= cfg_spm_mask;
                        lo_q       <= cfg_lo;
                        hi_q       <= cfg_hi;
                        ld_addr_q  <= cfg_lo;
                    end else if (accept) begin
                        req_addr_q <= fetch_addr;
                        wcnt_q     <= '0;
                        if (win_hit || cache_hit) begin
                            resp_valid <= 1'b1;
                            resp_data  <= rd_data;
                            resp_src   <= win_hit ? SRC_SPM : SRC_CACHE;
                        end else if (any_cache) begin
                            victim_q <= victim_oh;
                            rr_ptr_q <= victim_idx + BSEL_W'(1);
                        end
                    end
                end
                ST_LOAD: begin
                    if (mem_ack && win_hit) ld_addr_q <= ld_addr_q + ADDR_W'(WORD_BYTES);
                end
                ST_REFILL: begin
                    if (mem_ack) begin
                        wcnt_q <= wcnt_q + WPL_W'(1);
                        if (wcnt_q == req_word) cap_q <= mem_rdata;
                        if (wcnt_q == LAST_WORD) begin
                            resp_valid <= 1'b1;
                            resp_data  <= (wcnt_q == req_word) ? mem_rdata : cap_q;
                            resp_src   <= SRC_FILL;
                        end
                    end
                end
                ST_BYPASS: begin
                    if (mem_ack) begin
                        resp_valid <= 1'b1;
                        resp_data  <= mem_rdata;
                        resp_src   <= SRC_DIRECT;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/fm_checker.sv
module fm_checker #(
    parameter int NBANK  = 4,
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              resp_valid,
    input logic [NBANK-1:0]  tag_en,
    input logic [NBANK-1:0]  data_en,
    input logic              mem_req,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [NBANK-1:0]  spm_mask,
    input logic              lookup_hit
);

    assert_tag_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_en & spm_mask) == '0);

    assert_spm_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_en == '0 && data_en != '0) |-> ($onehot(data_en) && (data_en & ~spm_mask) == '0));

    assert_idle_lookup_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (tag_en == '0 && data_en == '0));

    assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    assert_hit_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (data_en != '0 && lookup_hit) |=> resp_valid);

    assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

endmodule

bind flexmem_ifetch fm_checker #(.NBANK(NBANK), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .resp_valid(resp_valid),
    .tag_en(tag_en), .data_en(data_en), .mem_req(mem_req), .mem_ack(mem_ack),
    .mem_addr(mem_addr), .spm_mask(spm_mask_q), .lookup_hit(win_hit || cache_hit)
);

// File: tb/sim_flexmem_ifetch.sv
module sim_flexmem_ifetch;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_valid = 1'b0;
    logic [3:0]  cfg_spm_mask = '0;
    logic [15:0] cfg_lo = '0, cfg_hi = '0;
    logic        fetch_valid = 1'b0;
    logic [15:0] fetch_addr = '0;
    logic        busy, resp_valid, mem_req;
    logic        mem_ack = 1'b0;
    logic [31:0] resp_data, mem_rdata;
    logic [1:0]  resp_src;
    logic [3:0]  tag_en, data_en;
    logic [15:0] mem_addr;

    int checks = 0, fails = 0, cyc = 0;
    logic [15:0] memq [$];

    // behavioural model state
    int   mtag [4][16];
    bit   mval [4][16];
    int   mptr = 0;
    logic [3:0] mmask = '0;
    int   mlo = 0, mhi = 0;

    flexmem_ifetch u0 (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_spm_mask(cfg_spm_mask),
        .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .busy(busy), .resp_valid(resp_valid), .resp_data(resp_data), .resp_src(resp_src),
        .tag_en(tag_en), .data_en(data_en), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] mw(input logic [15:0] a);
        return {a ^ 16'hC3A5, ~a};
    endfunction

    assign mem_rdata = mw(mem_addr);

    always @(posedge clk) begin
        if (mem_req && mem_ack) memq.push_back(mem_addr);
        mem_ack <= rst_n && mem_req && !mem_ack;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: got %0d cycles expected < 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic int win_bank(input int a);
        int off, ord, cnt;
        if (a < mlo || a >= mhi) return -1;
        off = a - mlo;
        ord = off >> 8;
        if (ord > 3) return -1;
        cnt = 0;
        for (int b = 0; b < 4; b++) begin
            if (mmask[b]) begin
                if (cnt == ord) return b;
                cnt++;
            end
        end
        return -1;
    endfunction

    task automatic do_fetch(input logic [15:0] a);
        int wb, w, set, tg, n, esrc;
        logic [3:0] et, ed;
        set = (a >> 4) & 15;
        tg  = a >> 8;
        wb  = win_bank(a);
        w   = -1;
        if (wb >= 0) begin
            esrc = 1; et = 4'b0; ed = 4'(1 << wb);
        end else begin
            et = ~mmask; ed = ~mmask;
            for (int ww = 0; ww < 4; ww++)
                if (!mmask[ww] && mval[ww][set] && mtag[ww][set] == tg) w = ww;
            if (w >= 0) esrc = 0;
            else if (mmask != 4'hF) esrc = 2;
            else esrc = 3;
        end
        memq.delete();
        @(negedge clk);
        fetch_valid = 1'b1;
        fetch_addr  = a;
        #1;
        chk(busy == 1'b0, "R11 idle before fetch", 32'(busy), 0);
        chk(tag_en == et, (esrc == 1) ? "R5 tag_en gated" : "R6 tag_en cache ways", 32'(tag_en), 32'(et));
        chk(data_en == ed, (esrc == 1) ? "R5 data_en one bank (R4 map)" : "R6 data_en cache ways", 32'(data_en), 32'(ed));
        @(negedge clk);
        fetch_valid = 1'b0;
        n = 0;
        while (!resp_valid && n < 100) begin
            @(negedge clk);
            n++;
        end
        if (esrc <= 1) chk(n == 0, "R6 next-cycle hit response", 32'(n), 0);
        chk(resp_data == mw(a), "R5/R7 response data", resp_data, mw(a));
        chk(resp_src == 2'(esrc), (esrc == 3) ? "R10 source" : "R7/R8 source", 32'(resp_src), 32'(esrc));
        if (esrc == 2) begin
            chk(memq.size() == 4, "R7 refill read count", 32'(memq.size()), 4);
            for (int i = 0; i < 4 && i < memq.size(); i++)
                chk(memq[i] == ((a & 16'hFFF0) + 16'(4*i)), "R7 refill order", 32'(memq[i]), 32'((a & 16'hFFF0) + 16'(4*i)));
            for (int k = 0; k < 4; k++) begin
                int v;
                v = (mptr + k) % 4;
                if (!mmask[v]) begin
                    mval[v][set] = 1'b1;
                    mtag[v][set] = tg;
                    mptr = (v + 1) % 4;
                    break;
                end
            end
        end else if (esrc == 3) begin
            chk(memq.size() == 1, "R10 single uncached read", 32'(memq.size()), 1);
        end else begin
            chk(memq.size() == 0, "R5 no memory traffic on hit", 32'(memq.size()), 0);
        end
    endtask

    task automatic do_cfg(input logic [3:0] m, input logic [15:0] lo, input logic [15:0] hi);
        int cnt, n;
        for (int w = 0; w < 4; w++)
            if (m[w] != mmask[w])
                for (int s = 0; s < 16; s++) mval[w][s] = 1'b0;
        mmask = m; mlo = lo; mhi = hi;
        cnt = 0;
        while (win_bank(mlo + 4*cnt) >= 0) cnt++;
        memq.delete();
        @(negedge clk);
        cfg_valid = 1'b1; cfg_spm_mask = m; cfg_lo = lo; cfg_hi = hi;
        @(negedge clk);
        cfg_valid = 1'b0;
        chk(busy == 1'b1, "R2 busy during load", 32'(busy), 1);
        if (cnt > 0) begin
            fetch_valid = 1'b1;
            fetch_addr  = lo;
            #1;
            chk(data_en == 4'b0 && tag_en == 4'b0, "R11 no lookup while busy", 32'({tag_en, data_en}), 0);
            @(negedge clk);
            fetch_valid = 1'b0;
            chk(resp_valid == 1'b0, "R11 no response while busy", 32'(resp_valid), 0);
        end
        n = 0;
        while (busy && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(memq.size() == cnt, "R2 load word count", 32'(memq.size()), 32'(cnt));
        if (cnt > 0) chk(memq[0] == lo, "R2 load start address", 32'(memq[0]), 32'(lo));
    endtask

    initial begin
        for (int w = 0; w < 4; w++)
            for (int s = 0; s < 16; s++) begin mval[w][s] = 1'b0; mtag[w][s] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !resp_valid && !mem_req, "R1 reset outputs", 32'({busy, resp_valid, mem_req}), 0);
        chk(tag_en == 0 && data_en == 0, "R1 reset enables", 32'({tag_en, data_en}), 0);

        // all cache: refill then hit
        do_fetch(16'h1234);
        do_fetch(16'h1238);
        // round robin in set 3, fifth tag evicts the first line
        do_fetch(16'h1030);
        do_fetch(16'h2030);
        do_fetch(16'h3030);
        do_fetch(16'h4030);
        do_fetch(16'h1234);   // R8: evicted, misses again
        do_fetch(16'h4034);   // R8: still resident

        // banks 1 and 3 scratchpad, window spans one and a half banks
        do_cfg(4'b1010, 16'h8000, 16'h8180);
        do_fetch(16'h8004);   // ordinal 0 -> bank 1
        do_fetch(16'h8104);   // ordinal 1 -> bank 3
        do_fetch(16'h817C);   // last word inside
        do_fetch(16'h8180);   // end address is exclusive
        do_fetch(16'h7FFC);   // below start
        do_fetch(16'h4030);   // R9: bank of this line may have changed
        do_fetch(16'h4030);

        // only bank 0 scratchpad: ordinal 1 is outside the window (R4)
        do_cfg(4'b0001, 16'hA000, 16'hA400);
        do_fetch(16'hA0FC);
        do_fetch(16'hA100);

        // all scratchpad: uncached path
        do_cfg(4'b1111, 16'h9000, 16'h9400);
        do_fetch(16'h93FC);
        do_fetch(16'h1000);
        do_fetch(16'h1000);   // R10: nothing allocated

        // back to all cache: every line cleared (R9)
        do_cfg(4'b0000, 16'h0000, 16'h0000);
        do_fetch(16'h4030);
        do_fetch(16'h4030);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule